// File: doc/BRIEF.md
# Multichannel SAR Conversion Sequencer

This block is the digital side of an eight-channel, ten-bit successive-approximation converter. Software writes a channel enable mask and starts a scan with a command write. The sequencer then walks through the enabled channels from the lowest index upwards. For each channel it performs a binary search, one bit per clock and starting at the MSB, against a single comparator input. The search value is shown to the analog side on `dac_code`, and the final code goes into that channel's own result register.

Each stored result raises a one-cycle transfer request that a DMA engine can service by reading the matching data register. The end of the scan raises a completion strobe and sets a held interrupt. If the auto-sleep control bit is set, the converter then moves to a sleep state. A later start command wakes it, and conversion begins after a fixed two-cycle settling delay. Register access uses a simple valid/ready bus that completes in the same cycle.

Top module: `sar_scan_ctrl`

## Requirements
- R1: After reset the sequencer is idle and awake. `irq`, `seq_done`, `dma_req` and `conv_active` are low, and every register reads zero.
- R2: Address 0 holds the control word: bits [7:0] are the per-channel enables and bit 8 is auto-sleep. It reads back as written.
- R3: Writing 1 to bit 0 of address 1 while idle starts a scan. During the scan `conv_active` is high and `conv_chan` steps through the enabled channels in ascending order. Disabled channels are skipped.
- R4: Each channel takes exactly 10 cycles. In each cycle `dac_code` is the bits kept so far plus one trial bit, going from bit 9 down to bit 0. A trial bit is kept when `cmp_hi` is 1 in that cycle.
- R5: The final code of channel c is stored in the register at address 8+c (bits [9:0]), and flag bit c of address 2 is set.
- R6: Reading the data register at address 8+c clears flag bit c.
- R7: `dma_req` pulses for one cycle right after each result is stored, and `dma_chan` gives that channel.
- R8: `seq_done` pulses for one cycle when the last enabled channel finishes, and `irq` is set in the same cycle. `irq` reads as bit 8 of address 2 and stays set until a write to address 2 with bit 8 set.
- R9: A start command issued with an empty enable mask completes in the next cycle, with `seq_done` and `irq` raised.
- R10: A start command issued during a scan or during wake-up has no effect.
- R11: When auto-sleep is set, the block enters sleep at the end of a scan. `adc_sleep` goes high, and address 1 reads 2 (bit 1 = asleep, bit 0 = busy).
- R12: A start command in sleep drops `adc_sleep` at once. `conv_active` stays low for two cycles and then rises on the lowest enabled channel.
- R13: `bus_ready` follows `bus_valid` in the same cycle, `bus_rdata` is valid in that cycle, and unmapped addresses 3 to 7 read zero.
- R14: Enable changes written during a scan affect only the next scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 9 | Write data |
| bus_ready | output | 1 | Access accepted |
| bus_rdata | output | 16 | Read data |
| cmp_hi | input | 1 | Comparator: input at or above `dac_code` |
| dac_code | output | 10 | Trial code for the DAC, zero when not converting |
| conv_active | output | 1 | A channel is being converted |
| conv_chan | output | 3 | Channel being converted |
| adc_sleep | output | 1 | Converter asleep |
| irq | output | 1 | Held end-of-scan interrupt |
| seq_done | output | 1 | One-cycle end-of-scan strobe |
| dma_req | output | 1 | One-cycle result transfer request |
| dma_chan | output | 3 | Channel of the pending result |

## Verification
The bench uses the default parameters: eight channels, ten-bit results and a two-cycle wake-up. A full scan is therefore short enough that one test can run several full scans. These include the all-zero and full-scale input codes, a sparse mask with gaps between channels, an empty mask, and a sleep and wake cycle. The comparator is modelled from a per-channel input level, so each stored result can be predicted as that level exactly.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_CONV  = 2'd2,
    ST_SLEEP = 2'd3
  } seq_state_t;

  localparam int ADR_CTRL = 0;
  localparam int ADR_CMD  = 1;
  localparam int ADR_FLAG = 2;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_sync_n = shift_q[1];
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           cmp_hi,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result,
  output logic           last
);
  localparam int KW = $clog2(RES);

  logic [RES-1:0] acc_q, acc_d;
  logic [KW-1:0]  k_q, k_d;
  logic [RES-1:0] bit_mask;

  assign bit_mask = {{(RES-1){1'b0}}, 1'b1} << k_q;
  assign trial    = acc_q | bit_mask;
  assign result   = cmp_hi ? trial : acc_q;
  assign last     = (k_q == '0);

  always_comb begin
    acc_d = acc_q;
    k_d   = k_q;
    if (step) begin
      if (last) begin
        acc_d = '0;
        k_d   = KW'(RES - 1);
      end else begin
        acc_d = result;
        k_d   = k_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      k_q   <= KW'(RES - 1);
    end else if (step) begin
      acc_q <= acc_d;
      k_q   <= k_d;
    end
  end
endmodule

// File: rtl/sar_chan_bank.sv
module sar_chan_bank #(
  parameter int NCH = 8,
  parameter int RES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [$clog2(NCH)-1:0] wr_ch,
  input  logic [RES-1:0]     wr_val,
  input  logic               rd_en,
  input  logic [$clog2(NCH)-1:0] rd_ch,
  output logic [NCH*RES-1:0] data_flat,
  output logic [NCH-1:0]     flags
);
  localparam int CW = $clog2(NCH);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic           hit_wr, hit_rd;
    logic [RES-1:0] data_q;
    logic           flag_q, flag_d;

    assign hit_wr = wr_en && (wr_ch == CW'(g));
    assign hit_rd = rd_en && (rd_ch == CW'(g));

    always_comb begin
      flag_d = flag_q;
      if (hit_rd) flag_d = 1'b0;
      if (hit_wr) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        flag_q <= 1'b0;
      end else begin
        if (hit_wr) data_q <= wr_val;
        flag_q <= flag_d;
      end
    end

    assign data_flat[g*RES +: RES] = data_q;
    assign flags[g] = flag_q;
  end
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl #(
  parameter int NCH      = 8,
  parameter int RES      = 10,
  parameter int WAKE_CYC = 2,
  parameter int DW       = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [$clog2(NCH):0]   bus_addr,
  input  logic [NCH:0]           bus_wdata,
  output logic                   bus_ready,
  output logic [DW-1:0]          bus_rdata,
  input  logic                   cmp_hi,
  output logic [RES-1:0]         dac_code,
  output logic                   conv_active,
  output logic [$clog2(NCH)-1:0] conv_chan,
  output logic                   adc_sleep,
  output logic                   irq,
  output logic                   seq_done,
  output logic                   dma_req,
  output logic [$clog2(NCH)-1:0] dma_chan
);
  import sar_scan_pkg::*;

  localparam int CW = $clog2(NCH);
  localparam int AW = CW + 1;
  localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  logic rst_i_n;

  sar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // bus decode
  logic acc_rd, acc_wr, trig, irq_clr, ctrl_wr, data_rd;
  assign acc_rd  = bus_valid && !bus_write;
  assign acc_wr  = bus_valid && bus_write;
  assign trig    = acc_wr && (bus_addr == AW'(ADR_CMD)) && bus_wdata[0];
  assign irq_clr = acc_wr && (bus_addr == AW'(ADR_FLAG)) && bus_wdata[NCH];
  assign ctrl_wr = acc_wr && (bus_addr == AW'(ADR_CTRL));
  assign data_rd = acc_rd && bus_addr[AW-1];

  // state
  seq_state_t      state_q, state_d;
  logic [WW-1:0]   wcnt_q, wcnt_d;
  logic [NCH-1:0]  pend_q, pend_d;
  logic [CW-1:0]   ch_q, ch_d;
  logic [NCH-1:0]  en_q, en_d;
  logic            as_q, as_d;
  logic            irq_q, irq_d;
  logic            done_q, done_d;
  logic            dma_q, dma_d;
  logic [CW-1:0]   dmach_q, dmach_d;

  logic            step, last, wr_en;
  logic [RES-1:0]  trial, result;
  logic [NCH*RES-1:0] data_flat;
  logic [NCH-1:0]  flags;

  function automatic logic [CW-1:0] lowest(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) r = CW'(i);
    end
    return r;
  endfunction

  sar_approx #(.RES(RES)) u_approx (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .step   (step),
    .cmp_hi (cmp_hi),
    .trial  (trial),
    .result (result),
    .last   (last)
  );

  sar_chan_bank #(.NCH(NCH), .RES(RES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .wr_ch     (ch_q),
    .wr_val    (result),
    .rd_en     (data_rd),
    .rd_ch     (bus_addr[CW-1:0]),
    .data_flat (data_flat),
    .flags     (flags)
  );

  // next state
  always_comb begin
    logic           launch, finish;
    logic [NCH-1:0] launch_mask, rem;
    state_d     = state_q;
    wcnt_d      = wcnt_q;
    pend_d      = pend_q;
    ch_d        = ch_q;
    irq_d       = irq_q & ~irq_clr;
    done_d      = 1'b0;
    dma_d       = 1'b0;
    dmach_d     = dmach_q;
    step        = 1'b0;
    wr_en       = 1'b0;
    launch      = 1'b0;
    finish      = 1'b0;
    launch_mask = '0;
    rem         = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) begin
          launch      = 1'b1;
          launch_mask = en_q;
        end
      end
      ST_SLEEP: begin
        if (trig) begin
          state_d = ST_WAKE;
          wcnt_d  = '0;
          pend_d  = en_q;
        end
      end
      ST_WAKE: begin
        if (wcnt_q == WW'(WAKE_CYC - 1)) begin
          launch      = 1'b1;
          launch_mask = pend_q;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        step = 1'b1;
        if (last) begin
          wr_en   = 1'b1;
          dma_d   = 1'b1;
          dmach_d = ch_q;
          rem     = pend_q & ~({{(NCH-1){1'b0}}, 1'b1} << ch_q);
          pend_d  = rem;
          if (rem == '0) finish = 1'b1;
          else           ch_d   = lowest(rem);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (launch) begin
      if (launch_mask == '0) begin
        finish = 1'b1;
      end else begin
        state_d = ST_CONV;
        pend_d  = launch_mask;
        ch_d    = lowest(launch_mask);
      end
    end
    if (finish) begin
      done_d  = 1'b1;
      irq_d   = 1'b1;
      state_d = as_q ? ST_SLEEP : ST_IDLE;
    end
  end

  always_comb begin
    en_d = ctrl_wr ? bus_wdata[NCH-1:0] : en_q;
    as_d = ctrl_wr ? bus_wdata[NCH]     : as_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      pend_q  <= '0;
      ch_q    <= '0;
      en_q    <= '0;
      as_q    <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
      dma_q   <= 1'b0;
      dmach_q <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      pend_q  <= pend_d;
      ch_q    <= ch_d;
      en_q    <= en_d;
      as_q    <= as_d;
      irq_q   <= irq_d;
      done_q  <= done_d;
      dma_q   <= dma_d;
      dmach_q <= dmach_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1]) begin
      bus_rdata[RES-1:0] = data_flat[int'(bus_addr[CW-1:0]) * RES +: RES];
    end else if (bus_addr == AW'(ADR_CTRL)) begin
      bus_rdata[NCH:0] = {as_q, en_q};
    end else if (bus_addr == AW'(ADR_CMD)) begin
      bus_rdata[1:0] = {state_q == ST_SLEEP,
                        (state_q == ST_WAKE) || (state_q == ST_CONV)};
    end else if (bus_addr == AW'(ADR_FLAG)) begin
      bus_rdata[NCH:0] = {irq_q, flags};
    end
  end

  assign bus_ready   = bus_valid;
  assign conv_active = (state_q == ST_CONV);
  assign conv_chan   = ch_q;
  assign dac_code    = conv_active ? trial : '0;
  assign adc_sleep   = (state_q == ST_SLEEP);
  assign irq         = irq_q;
  assign seq_done    = done_q;
  assign dma_req     = dma_q;
  assign dma_chan    = dmach_q;
endmodule

// File: rtl/sar_scan_chk.sv
module sar_scan_chk #(
  parameter int NCH = 8,
  parameter int RES = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_ready,
  input logic                   conv_active,
  input logic [$clog2(NCH)-1:0] conv_chan,
  input logic [RES-1:0]         dac_code,
  input logic                   adc_sleep,
  input logic                   irq,
  input logic                   seq_done,
  input logic                   dma_req
);
  // R13
  bus_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_ready);

  // R4
  trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_active |-> (dac_code != '0));

  // R3
  chan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && $past(conv_active) && (conv_chan != $past(conv_chan)))
      |-> (conv_chan > $past(conv_chan)));

  // R7
  dma_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(conv_active));

  // R7
  dma_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !conv_active) |=> !dma_req);

  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> irq);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sleep |-> !conv_active);
endmodule

bind sar_scan_ctrl sar_scan_chk #(.NCH(NCH), .RES(RES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .conv_active (conv_active),
  .conv_chan   (conv_chan),
  .dac_code    (dac_code),
  .adc_sleep   (adc_sleep),
  .irq         (irq),
  .seq_done    (seq_done),
  .dma_req     (dma_req)
);

// File: tb/sim_sar_scan_ctrl.sv
module sim_sar_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int RES = 10;
  localparam int CW  = 3;
  localparam int AW  = 4;

  logic          clk, rst_n;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [NCH:0]  bus_wdata;
  logic          bus_ready;
  logic [15:0]   bus_rdata;
  logic          cmp_hi;
  logic [RES-1:0] dac_code;
  logic          conv_active, adc_sleep, irq, seq_done, dma_req;
  logic [CW-1:0] conv_chan, dma_chan;

  int checks, fails, done_cnt;
  bit model_on;
  int ain [NCH];

  sar_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .conv_active(conv_active), .conv_chan(conv_chan), .adc_sleep(adc_sleep),
    .irq(irq), .seq_done(seq_done), .dma_req(dma_req), .dma_chan(dma_chan)
  );

  // analog stand-in: input level at or above the trial code
  assign cmp_hi = (int'(dac_code) <= ain[conv_chan]);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_state, m_wcnt, m_pend, m_ch, m_k, m_acc, m_en, m_as;
  int m_flags, m_irq, m_done, m_dma, m_dmach;
  int m_data [NCH];

  function automatic int low_bit(int m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic model_step();
    int trig, launch, lmask, fin, trial, addr;
    addr = int'(bus_addr);
    if (bus_valid && !bus_write && addr >= 8) m_flags &= ~(1 << (addr - 8));
    if (bus_valid && bus_write && addr == 2 && bus_wdata[8]) m_irq = 0;
    trig = (bus_valid && bus_write && addr == 1 && bus_wdata[0]) ? 1 : 0;
    m_done = 0; m_dma = 0; launch = 0; lmask = 0; fin = 0;
    case (m_state)
      0: if (trig != 0) begin launch = 1; lmask = m_en; end
      3: if (trig != 0) begin m_state = 1; m_wcnt = 0; m_pend = m_en; end
      1: begin
        if (m_wcnt == 1) begin launch = 1; lmask = m_pend; end
        else m_wcnt++;
      end
      default: begin
        trial = m_acc | (1 << m_k);
        if (trial <= ain[m_ch]) m_acc = trial;
        if (m_k == 0) begin
          m_data[m_ch] = m_acc;
          m_flags |= (1 << m_ch);
          m_dma = 1; m_dmach = m_ch;
          m_pend &= ~(1 << m_ch);
          m_acc = 0; m_k = 9;
          if (m_pend == 0) fin = 1;
          else m_ch = low_bit(m_pend);
        end else m_k--;
      end
    endcase
    if (launch != 0) begin
      if (lmask == 0) fin = 1;
      else begin
        m_state = 2; m_pend = lmask; m_ch = low_bit(lmask); m_acc = 0; m_k = 9;
      end
    end
    if (fin != 0) begin
      m_done = 1; m_irq = 1;
      m_state = (m_as != 0) ? 3 : 0;
    end
    if (bus_valid && bus_write && addr == 0) begin
      m_en = int'(bus_wdata[7:0]); m_as = int'(bus_wdata[8]);
    end
  endtask

  always @(posedge clk) if (model_on) model_step();

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      if (seq_done) done_cnt++;
      check("R3 conv_active", int'(conv_active), (m_state == 2) ? 1 : 0);
      if (m_state == 2) begin
        check("R3 conv_chan", int'(conv_chan), m_ch);
        check("R4 dac_code", int'(dac_code), m_acc | (1 << m_k));
      end else begin
        check("R4 dac_code idle", int'(dac_code), 0);
      end
      check("R11 adc_sleep", int'(adc_sleep), (m_state == 3) ? 1 : 0);
      check("R8 irq", int'(irq), m_irq);
      check("R8 seq_done", int'(seq_done), m_done);
      check("R7 dma_req", int'(dma_req), m_dma);
      if (m_dma != 0) check("R7 dma_chan", int'(dma_chan), m_dmach);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(int addr, int data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = AW'(addr); bus_wdata = (NCH+1)'(data);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(string tag, int addr, int exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
    #1;
    check({tag, " rdata"}, int'(bus_rdata), exp);
    check("R13 bus_ready", int'(bus_ready), 1);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_scan();
    for (int i = 0; i < 400; i++) begin
      if (m_state != 1 && m_state != 2) break;
      @(negedge clk);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    checks = 0; fails = 0; done_cnt = 0; model_on = 0;
    m_state = 0; m_wcnt = 0; m_pend = 0; m_ch = 0; m_k = 9; m_acc = 0;
    m_en = 0; m_as = 0; m_flags = 0; m_irq = 0; m_done = 0; m_dma = 0; m_dmach = 0;
    for (int i = 0; i < NCH; i++) begin m_data[i] = 0; ain[i] = 0; end
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 adc_sleep", int'(adc_sleep), 0);
    check("R1 conv_active", int'(conv_active), 0);
    bus_rd("R1 ctrl", 0, 0);
    bus_rd("R1 status", 1, 0);
    bus_rd("R1 flags", 2, 0);
    bus_rd("R1 data3", 11, 0);

    // R2: control readback
    bus_wr(0, 'hA5);
    bus_rd("R2 ctrl", 0, 'hA5);

    // scan 1: sparse mask; mid-scan enable change (R14) and ignored start (R10)
    ain[0] = 300; ain[2] = 1; ain[5] = 777; ain[7] = 1022;
    ain[1] = 50; ain[3] = 60; ain[4] = 70; ain[6] = 80;
    bus_wr(1, 1);
    repeat (3) @(negedge clk);
    bus_wr(0, 'hFF);
    bus_wr(1, 1);
    wait_scan();
    repeat (2) @(negedge clk);
    check("R10 single done", done_cnt, 1);
    bus_rd("R14 R5 flags", 2, 'h1A5);
    bus_rd("R5 data0", 8, 300);
    bus_rd("R5 data2", 10, 1);
    bus_rd("R5 data5", 13, 777);
    bus_rd("R5 data7", 15, 1022);
    bus_rd("R14 skipped data1", 9, 0);
    bus_rd("R6 flags cleared", 2, 'h100);
    bus_wr(2, 'h100);
    bus_rd("R8 irq cleared", 2, 0);
    bus_rd("R2 ctrl new mask", 0, 'hFF);

    // scan 2: all channels, extreme and mid-scale codes
    ain[0] = 0; ain[1] = 1023; ain[2] = 512; ain[3] = 511;
    ain[4] = 341; ain[5] = 682; ain[6] = 2; ain[7] = 1021;
    bus_wr(1, 1);
    wait_scan();
    for (int c = 0; c < NCH; c++) bus_rd("R4 R5 data", 8 + c, ain[c]);
    bus_rd("R6 flags after reads", 2, 'h100);
    bus_wr(2, 'h100);

    // R9: empty mask
    bus_wr(0, 0);
    bus_wr(1, 1);
    check("R9 seq_done", int'(seq_done), 1);
    check("R9 irq", int'(irq), 1);
    bus_wr(2, 'h100);

    // R11: auto-sleep
    ain[0] = 123; ain[7] = 456;
    bus_wr(0, 'h181);
    bus_wr(1, 1);
    wait_scan();
    @(negedge clk);
    check("R11 asleep", int'(adc_sleep), 1);
    bus_rd("R11 status", 1, 2);

    // R12: wake-up delay
    ain[0] = 900;
    bus_wr(1, 1);
    check("R12 awake", int'(adc_sleep), 0);
    check("R12 wake cycle 1", int'(conv_active), 0);
    @(negedge clk);
    check("R12 wake cycle 2", int'(conv_active), 0);
    @(negedge clk);
    check("R12 conv starts", int'(conv_active), 1);
    check("R12 first chan", int'(conv_chan), 0);
    wait_scan();
    bus_rd("R12 data0", 8, 900);

    // R13: unmapped addresses
    for (int a = 3; a < 8; a++) bus_rd("R13 unmapped", a, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule